// File: doc/BRIEF.md
# Memory Request Byte-Enable Legality Checker

This block inspects the header fields of one memory request per cycle and decides whether the first-DW and last-DW byte-enable patterns obey the transfer rules for the request's length. Its inputs are the 10-bit DW length, both 4-bit byte-enable fields, address bit 2 and a read/write flag. A registered verdict appears one clock after the request is presented. The verdict holds a legal flag, a 3-bit reason code naming the first rule that failed, and two advisory flags. One flag marks a 1 DW read with no bytes enabled, which acts as a flush and returns one DW of undefined data. The other marks a 1 DW write with no bytes enabled, which is legal but changes nothing at the target.

Internally the request is sorted into one of three length classes. CLS_SINGLE covers a length of 1. CLS_PAIR covers a length of 2. CLS_BURST covers a length of 3 or more, and also a length field of 0, which stands for 1024 DW. A combinational rule evaluator applies the rules of the selected class in a fixed priority order. The result register has two states. It moves from RES_IDLE to RES_FRESH on any cycle with a valid request. It moves from RES_FRESH back to RES_IDLE on a cycle without one, and stays in RES_IDLE otherwise. In RES_IDLE the last verdict is held unchanged.

Top module: `be_legality_chk`

## Requirements
- R1: `chk_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low after reset. After reset `chk_legal`=1, `chk_reason`=0 and both flags are 0.
- R2: A length of 1 with a nonzero last byte enable is illegal with reason 1.
- R3: A length other than 1 (including 0) with first byte enable 0000b is illegal with reason 2.
- R4: For a length of 3 or more, a non-contiguous first byte enable is illegal with reason 3. A pattern is contiguous when its set bits form one unbroken run; 0000b is contiguous.
- R5: For a length of 3 or more, a non-contiguous last byte enable is illegal with reason 4, when rules 1 to 3 pass.
- R6: For a length of 2 with address bit 2 set, a non-contiguous pattern in either field is illegal with reason 5. With address bit 2 clear, such patterns are legal.
- R7: For a length of 1, any first byte enable, including a non-contiguous one, is legal when the last byte enable is 0000b.
- R8: A legal 1 DW read with both byte enables 0000b sets `chk_flush` and clears `chk_noeffect`.
- R9: A legal 1 DW write with both byte enables 0000b sets `chk_noeffect` and clears `chk_flush`. Neither flag is set on any other request.
- R10: A length field of 0 is treated as 1024 DW and follows the rules for 3 or more.
- R11: When several rules fail, the lowest reason code is reported. `chk_legal` is 1 exactly when `chk_reason` is 0.
- R12: In a cycle following one without `req_valid`, the legal flag, reason and both advisory flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request fields are valid this cycle |
| req_len | input | 10 | Length in DW, 0 meaning 1024 |
| req_first_be | input | 4 | First DW byte enables |
| req_last_be | input | 4 | Last DW byte enables |
| req_addr2 | input | 1 | Address bit 2 (0 = quadword aligned) |
| req_is_write | input | 1 | 1 for write, 0 for read |
| chk_valid | output | 1 | Verdict updated this cycle |
| chk_legal | output | 1 | Request obeys all rules |
| chk_reason | output | 3 | First failing rule, 0 when legal |
| chk_flush | output | 1 | Legal 1 DW read with no bytes enabled |
| chk_noeffect | output | 1 | Legal 1 DW write with no bytes enabled |

## Verification
A length class chosen wrongly shows up on the next clock as a wrong reason code. The clearest cases are length 0 or 2 being judged as a single DW, or a 2 DW request being judged by the burst rules. A broken contiguity detector shows up as reason 3, 4 or 5 being reported or missed for exactly the gapped patterns, one cycle after the request. A result register that fails to hold in RES_IDLE, or that runs ahead of or behind the request, appears at once as a `chk_valid` mismatch or a verdict that changes in a cycle where no request was presented.

// File: rtl/be_chk_pkg.sv
package be_chk_pkg;

    typedef enum logic [1:0] {
        CLS_SINGLE = 2'd0,
        CLS_PAIR   = 2'd1,
        CLS_BURST  = 2'd2
    } len_class_e;

    typedef enum logic [2:0] {
        RSN_OK          = 3'd0,
        RSN_LAST_ON_ONE = 3'd1,
        RSN_FIRST_EMPTY = 3'd2,
        RSN_FIRST_GAP   = 3'd3,
        RSN_LAST_GAP    = 3'd4,
        RSN_PAIR_ALIGN  = 3'd5
    } reason_e;

    typedef enum logic {
        RES_IDLE  = 1'b0,
        RES_FRESH = 1'b1
    } res_state_e;

    typedef struct packed {
        logic    legal;
        reason_e reason;
        logic    flush;
        logic    noeffect;
    } verdict_t;

endpackage

// File: rtl/be_contig_det.sv
module be_contig_det #(
    parameter int W = 4
) (
    input  logic [W-1:0] pat,
    output logic         contig
);
    // Each bit that is set while its lower neighbour is clear starts a run.
    logic [W-1:0] run_start;

    assign run_start[0] = pat[0];

    for (genvar i = 1; i < W; i++) begin : g_start
        assign run_start[i] = pat[i] & ~pat[i-1];
    end

    assign contig = ($countones(run_start) <= 1);
endmodule

// File: rtl/be_len_class.sv
module be_len_class
    import be_chk_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic [LEN_W-1:0] len,
    output len_class_e       cls
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] LEN_TWO = LEN_W'(2);

    // A zero length encodes the maximum transfer and lands in CLS_BURST.
    always_comb begin
        if (len == LEN_ONE)      cls = CLS_SINGLE;
        else if (len == LEN_TWO) cls = CLS_PAIR;
        else                     cls = CLS_BURST;
    end
endmodule

// File: rtl/be_rule_eval.sv
module be_rule_eval
    import be_chk_pkg::*;
#(
    parameter int BE_W = 4
) (
    input  len_class_e       cls,
    input  logic [BE_W-1:0]  first_be,
    input  logic [BE_W-1:0]  last_be,
    input  logic             first_contig,
    input  logic             last_contig,
    input  logic             addr2,
    input  logic             is_write,
    output verdict_t         verdict
);
    logic fb_empty;
    logic lb_empty;
    logic pass_last_one;
    logic pass_first_empty;
    logic pass_first_gap;
    logic pass_last_gap;
    logic pass_pair_align;
    logic empty_single;

    assign fb_empty = ~|first_be;
    assign lb_empty = ~|last_be;

    // Per-rule pass bits, used for the legal flag.
    always_comb begin
        pass_last_one    = 1'b1;
        pass_first_empty = 1'b1;
        pass_first_gap   = 1'b1;
        pass_last_gap    = 1'b1;
        pass_pair_align  = 1'b1;
        unique case (cls)
            CLS_SINGLE: begin
                pass_last_one = lb_empty;
            end
            CLS_PAIR: begin
                pass_first_empty = !fb_empty;
                pass_pair_align  = !addr2 || (first_contig && last_contig);
            end
            CLS_BURST: begin
                pass_first_empty = !fb_empty;
                pass_first_gap   = first_contig;
                pass_last_gap    = last_contig;
            end
            default: begin
                pass_last_one = 1'b0;
            end
        endcase
    end

    assign empty_single = (cls == CLS_SINGLE) && fb_empty && lb_empty;

    // Reason code: first failing rule in priority order.
    always_comb begin
        verdict.legal    = pass_last_one & pass_first_empty & pass_first_gap
                         & pass_last_gap & pass_pair_align;
        verdict.flush    = empty_single && !is_write;
        verdict.noeffect = empty_single && is_write;
        if (!pass_last_one)         verdict.reason = RSN_LAST_ON_ONE;
        else if (!pass_first_empty) verdict.reason = RSN_FIRST_EMPTY;
        else if (!pass_first_gap)   verdict.reason = RSN_FIRST_GAP;
        else if (!pass_last_gap)    verdict.reason = RSN_LAST_GAP;
        else if (!pass_pair_align)  verdict.reason = RSN_PAIR_ALIGN;
        else                        verdict.reason = RSN_OK;
    end
endmodule

// File: rtl/be_legality_chk.sv
module be_legality_chk
    import be_chk_pkg::*;
#(
    parameter int LEN_W = 10,
    parameter int BE_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    input  logic [BE_W-1:0]  req_first_be,
    input  logic [BE_W-1:0]  req_last_be,
    input  logic             req_addr2,
    input  logic             req_is_write,
    output logic             chk_valid,
    output logic             chk_legal,
    output logic [2:0]       chk_reason,
    output logic             chk_flush,
    output logic             chk_noeffect
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    len_class_e cls;
    logic       first_contig;
    logic       last_contig;
    verdict_t   next_verdict;
    verdict_t   verdict_q;
    res_state_e state_q;
    res_state_e state_d;

    be_len_class #(.LEN_W(LEN_W)) u_cls (
        .len (req_len),
        .cls (cls)
    );

    be_contig_det #(.W(BE_W)) u_first (
        .pat    (req_first_be),
        .contig (first_contig)
    );

    be_contig_det #(.W(BE_W)) u_last (
        .pat    (req_last_be),
        .contig (last_contig)
    );

    be_rule_eval #(.BE_W(BE_W)) u_rules (
        .cls          (cls),
        .first_be     (req_first_be),
        .last_be      (req_last_be),
        .first_contig (first_contig),
        .last_contig  (last_contig),
        .addr2        (req_addr2),
        .is_write     (req_is_write),
        .verdict      (next_verdict)
    );

    always_comb begin
        unique case (state_q)
            RES_IDLE:  state_d = req_valid ? RES_FRESH : RES_IDLE;
            RES_FRESH: state_d = req_valid ? RES_FRESH : RES_IDLE;
            default:   state_d = RES_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RES_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= '{legal: 1'b1, reason: RSN_OK, flush: 1'b0, noeffect: 1'b0};
        end else if (req_valid) begin
            verdict_q <= next_verdict;
        end
    end

    assign chk_valid    = (state_q == RES_FRESH);
    assign chk_legal    = verdict_q.legal;
    assign chk_reason   = verdict_q.reason;
    assign chk_flush    = verdict_q.flush;
    assign chk_noeffect = verdict_q.noeffect;

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> chk_valid);
    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !chk_valid);
    p_single_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_len == LEN_ONE && |req_last_be)
        |=> (!chk_legal && chk_reason == 3'd1));
    p_legal_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        chk_legal == (chk_reason == 3'd0));
    p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_flush && chk_noeffect));
    p_flag_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_flush || chk_noeffect) |-> chk_legal);
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(chk_reason) && $stable(chk_legal)
                        && $stable(chk_flush) && $stable(chk_noeffect)));
endmodule

// File: tb/be_legality_chk_test.sv
module be_legality_chk_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [9:0] req_len = '0;
    logic [3:0] req_first_be = '0;
    logic [3:0] req_last_be = '0;
    logic       req_addr2 = 1'b0;
    logic       req_is_write = 1'b0;
    logic       chk_valid;
    logic       chk_legal;
    logic [2:0] chk_reason;
    logic       chk_flush;
    logic       chk_noeffect;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    be_legality_chk uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
        .req_first_be(req_first_be), .req_last_be(req_last_be),
        .req_addr2(req_addr2), .req_is_write(req_is_write),
        .chk_valid(chk_valid), .chk_legal(chk_legal), .chk_reason(chk_reason),
        .chk_flush(chk_flush), .chk_noeffect(chk_noeffect)
    );

    // Contiguous: every bit between two set bits is also set.
    function automatic bit ref_contig(input logic [3:0] p);
        for (int i = 0; i < 4; i++)
            for (int j = i + 1; j < 4; j++)
                for (int k = i + 1; k < j; k++)
                    if (p[i] && p[j] && !p[k]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int ref_reason(input logic [9:0] len, input logic [3:0] fb,
                                      input logic [3:0] lb, input logic a2);
        int n = (len == 0) ? 1024 : int'(len);
        if (n == 1 && lb != 0) return 1;
        if (n > 1 && fb == 0) return 2;
        if (n >= 3 && !ref_contig(fb)) return 3;
        if (n >= 3 && !ref_contig(lb)) return 4;
        if (n == 2 && a2 && (!ref_contig(fb) || !ref_contig(lb))) return 5;
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input string req, input logic [9:0] len, input logic [3:0] fb,
                        input logic [3:0] lb, input logic a2, input logic w);
        int er;
        bit single_empty;
        er = ref_reason(len, fb, lb, a2);
        single_empty = (len == 1) && (fb == 0) && (lb == 0);
        @(negedge clk);
        req_valid = 1'b1; req_len = len; req_first_be = fb;
        req_last_be = lb; req_addr2 = a2; req_is_write = w;
        @(posedge clk); #2;
        check({req, " R1 valid"}, int'(chk_valid), 1);
        check({req, " reason"}, int'(chk_reason), er);
        check({req, " R11 legal"}, int'(chk_legal), (er == 0) ? 1 : 0);
        check({req, " R8 flush"}, int'(chk_flush), (single_empty && !w) ? 1 : 0);
        check({req, " R9 noeffect"}, int'(chk_noeffect), (single_empty && w) ? 1 : 0);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0] held_reason;
        logic       held_legal;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset valid", int'(chk_valid), 0);
        check("R1 reset legal", int'(chk_legal), 1);
        check("R1 reset reason", int'(chk_reason), 0);
        check("R1 reset flags", int'({chk_flush, chk_noeffect}), 0);
        @(negedge clk); rst_n = 1'b1;

        send("R2 single last set", 10'd1, 4'b1111, 4'b0001, 1'b0, 1'b0);
        send("R3 pair first empty", 10'd2, 4'b0000, 4'b1111, 1'b0, 1'b1);
        send("R3 burst first empty", 10'd8, 4'b0000, 4'b0101, 1'b0, 1'b0);
        send("R4 burst first gap", 10'd4, 4'b1001, 4'b1111, 1'b0, 1'b1);
        send("R11 first and last gap", 10'd5, 4'b0101, 4'b1010, 1'b0, 1'b0);
        send("R5 burst last gap", 10'd3, 4'b1100, 4'b1011, 1'b0, 1'b0);
        send("R6 pair misaligned gap", 10'd2, 4'b1111, 4'b0101, 1'b1, 1'b1);
        send("R6 pair aligned gap", 10'd2, 4'b1010, 4'b0101, 1'b0, 1'b1);
        send("R7 single gap first", 10'd1, 4'b1010, 4'b0000, 1'b1, 1'b1);
        send("R8 flush read", 10'd1, 4'b0000, 4'b0000, 1'b0, 1'b0);
        send("R9 noeffect write", 10'd1, 4'b0000, 4'b0000, 1'b1, 1'b1);
        send("R10 zero length gap", 10'd0, 4'b1101, 4'b1111, 1'b0, 1'b0);
        send("R10 zero length ok", 10'd0, 4'b1110, 4'b0011, 1'b0, 1'b1);

        // R12: an idle cycle leaves the verdict unchanged.
        send("R12 setup", 10'd4, 4'b0110, 4'b1111, 1'b0, 1'b0);
        held_reason = chk_reason; held_legal = chk_legal;
        @(negedge clk);
        req_first_be = 4'b0101; req_len = 10'd9;
        @(posedge clk); #2;
        check("R1 idle valid low", int'(chk_valid), 0);
        check("R12 hold reason", int'(chk_reason), int'(held_reason));
        check("R12 hold legal", int'(chk_legal), int'(held_legal));

        for (int it = 0; it < 400; it++) begin
            logic [9:0] l;
            int pick = $urandom_range(0, 5);
            case (pick)
                0: l = 10'd0;
                1: l = 10'd1;
                2: l = 10'd2;
                3: l = 10'd3;
                default: l = 10'($urandom_range(0, 1023));
            endcase
            send("random R2..R11", l, 4'($urandom), 4'($urandom),
                 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule